// File: doc/BRIEF.md
# Register-Hashed Indirect Branch Target Buffer

This block predicts the targets of indirect branches. It is a direct-mapped buffer indexed by the fetch PC. Each entry keeps a tag, the number of the source register the branch reads, and several target slots instead of a single target. A lookup returns the stored register number at once, on `lk_rnum`. The surrounding logic reads that register from the register file and returns its live value on `rf_data` in the same cycle. The block folds that value into a slot index and reports the target held in that slot. The prediction is registered and appears one cycle after the lookup.

When a branch resolves, the update port gives the branch PC, its source register number, the value that register held, and the actual target. The same fold of the value picks the slot that is written. The entry is allocated afresh if its tag does not match. If a lookup and an update address the same entry in the same cycle, the lookup sees the updated contents.

Top module: `rhbtb_top`

## Requirements
- R1: After reset every entry and every slot is invalid, so every lookup reports a miss until an update writes that entry.
- R2: A lookup presented with `lk_req` high at one clock edge gives `pred_valid` high for exactly the following cycle, carrying that lookup's result. With `lk_req` low, `pred_valid` is low in the following cycle.
- R3: `pred_hit` is 1 only when three conditions hold: the entry is valid, its stored tag equals `lk_pc[31:8]`, and the selected slot is valid. On a miss, `pred_target` reads zero.
- R4: The slot index is the XOR of all sixteen 2-bit fields of the 32-bit register value: slot = xor over k of value[2k+1:2k].
- R5: `lk_rnum` gives, in the same cycle and combinationally, the register number stored in the entry addressed by `lk_pc[7:2]`.
- R6: The entry index is PC bits [7:2]. Two PCs with the same index but different bits [31:8] share the entry and miss each other.
- R7: An update whose tag misses reloads the entry with the new tag and register number. It invalidates all other slots and writes the target into the hashed slot.
- R8: An update whose tag hits writes only the hashed slot and keeps every other slot's target and valid bit. It replaces the stored register number.
- R9: When an update and a lookup address the same entry in the same cycle, the lookup's result and its `lk_rnum` reflect the update.
- R10: Each entry holds four independent target slots, each with its own valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_rnum | output | 5 | Register number stored for the addressed entry (register-file read address) |
| rf_data | input | 32 | Register value returned for `lk_rnum` in the same cycle |
| pred_valid | output | 1 | Registered: a lookup result is present |
| pred_hit | output | 1 | Registered: the prediction is usable |
| pred_target | output | 32 | Registered: predicted target, zero on a miss |
| up_en | input | 1 | Update request from branch resolution |
| up_pc | input | 32 | PC of the resolved branch |
| up_rnum | input | 5 | Source register number of the branch |
| up_rval | input | 32 | Value of that register at resolution |
| up_target | input | 32 | Actual target of the branch |

## Verification
Corrupted metadata shows at the ports in the cycle of the next lookup to that entry. A wrong register number appears on `lk_rnum` at once, without waiting for a clock edge. A wrong tag or valid bit flips `pred_hit` one cycle later. A slot that was clobbered or left set shows up only when a register value folding to that slot is presented. For that reason the stimulus sweeps several fold results against one entry, and it follows each tag-miss reload with a lookup to a slot that should have been cleared. A faulty bypass would show only when a lookup and an update to the same entry share a cycle, so that case is driven directly.

// File: rtl/rhbtb_pkg.sv
package rhbtb_pkg;
    localparam int PC_W   = 32;
    localparam int DATA_W = 32;
    localparam int RNUM_W = 5;
    localparam int IDX_W  = 6;
    localparam int SLOTS  = 4;
    localparam int OFF_W  = 2;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int TAG_W  = PC_W - IDX_W - OFF_W;
    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [RNUM_W-1:0] rnum;
        logic [SLOTS-1:0]  svld;
    } meta_t;

    typedef struct packed {
        logic            hit;
        logic [PC_W-1:0] target;
    } pred_t;
endpackage

// File: rtl/rhbtb_hash.sv
module rhbtb_hash
    import rhbtb_pkg::*;
#(
    parameter int VAL_W = DATA_W,
    parameter int OUT_W = SLOT_W
) (
    input  logic [VAL_W-1:0] value,
    output logic [OUT_W-1:0] slot
);
    localparam int CHUNKS = VAL_W / OUT_W;

    always_comb begin
        slot = '0;
        for (int k = 0; k < CHUNKS; k++) begin
            slot = slot ^ value[k*OUT_W +: OUT_W];
        end
    end
endmodule

// File: rtl/rhbtb_store.sv
module rhbtb_store
    import rhbtb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      rd_idx,
    output meta_t                 rd_meta,
    output logic [SLOTS*PC_W-1:0] rd_tgts,
    input  logic [IDX_W-1:0]      up_idx,
    output meta_t                 up_meta,
    input  logic                  wr_en,
    input  meta_t                 wr_meta,
    input  logic [SLOT_W-1:0]     wr_slot,
    input  logic [PC_W-1:0]       wr_tgt
);
    logic                  valid_q [ENTRIES];
    logic [SLOTS-1:0]      svld_q  [ENTRIES];
    logic [TAG_W-1:0]      tag_q   [ENTRIES];
    logic [RNUM_W-1:0]     rnum_q  [ENTRIES];
    logic [PC_W-1:0]       tgt_q   [ENTRIES][SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                valid_q[e] <= 1'b0;
                svld_q[e]  <= '0;
            end
        end else if (wr_en) begin
            valid_q[up_idx] <= wr_meta.valid;
            svld_q[up_idx]  <= wr_meta.svld;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[up_idx]           <= wr_meta.tag;
            rnum_q[up_idx]          <= wr_meta.rnum;
            tgt_q[up_idx][wr_slot]  <= wr_tgt;
        end
    end

    always_comb begin
        rd_meta = '{valid: valid_q[rd_idx], tag: tag_q[rd_idx],
                    rnum: rnum_q[rd_idx], svld: svld_q[rd_idx]};
        up_meta = '{valid: valid_q[up_idx], tag: tag_q[up_idx],
                    rnum: rnum_q[up_idx], svld: svld_q[up_idx]};
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_rd
        assign rd_tgts[s*PC_W +: PC_W] = tgt_q[rd_idx][s];
    end

    AST_SLOTS_NEED_ENTRY: assert property (@(posedge clk) disable iff (rst)
        !rd_meta.valid |-> (rd_meta.svld == '0)); // R1
    AST_WRITE_MARKS_SLOT: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(up_idx)] && svld_q[$past(up_idx)][$past(wr_slot)])); // R7
endmodule

// File: rtl/rhbtb_top.sv
module rhbtb_top
    import rhbtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [PC_W-1:0]   lk_pc,
    output logic [RNUM_W-1:0] lk_rnum,
    input  logic [DATA_W-1:0] rf_data,
    output logic              pred_valid,
    output logic              pred_hit,
    output logic [PC_W-1:0]   pred_target,
    input  logic              up_en,
    input  logic [PC_W-1:0]   up_pc,
    input  logic [RNUM_W-1:0] up_rnum,
    input  logic [DATA_W-1:0] up_rval,
    input  logic [PC_W-1:0]   up_target
);
    logic [IDX_W-1:0]      lk_idx, up_idx;
    logic [TAG_W-1:0]      lk_tag, up_tag;
    logic [SLOT_W-1:0]     lk_slot, up_slot;
    meta_t                 rd_meta, old_meta, new_meta, view_meta;
    logic [SLOTS*PC_W-1:0] rd_tgts;
    logic [PC_W-1:0]       view_tgt;
    logic                  up_tag_hit, same_entry;
    pred_t                 pred_c, pred_q;
    logic                  pv_q;

    assign lk_idx = lk_pc[OFF_W +: IDX_W];
    assign lk_tag = lk_pc[PC_W-1 -: TAG_W];
    assign up_idx = up_pc[OFF_W +: IDX_W];
    assign up_tag = up_pc[PC_W-1 -: TAG_W];

    rhbtb_hash u_lk_hash (.value(rf_data), .slot(lk_slot));
    rhbtb_hash u_up_hash (.value(up_rval), .slot(up_slot));

    rhbtb_store u_store (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_meta(rd_meta), .rd_tgts(rd_tgts),
        .up_idx(up_idx), .up_meta(old_meta),
        .wr_en(up_en), .wr_meta(new_meta), .wr_slot(up_slot), .wr_tgt(up_target)
    );

    // Update: keep other slots only when the tag already matches
    always_comb begin
        up_tag_hit     = old_meta.valid && (old_meta.tag == up_tag);
        new_meta.valid = 1'b1;
        new_meta.tag   = up_tag;
        new_meta.rnum  = up_rnum;
        new_meta.svld  = (up_tag_hit ? old_meta.svld : '0) | (SLOTS'(1) << up_slot);
    end

    // Lookup sees a same-cycle update to its entry
    always_comb begin
        same_entry = up_en && (up_idx == lk_idx);
        view_meta  = same_entry ? new_meta : rd_meta;
        if (same_entry && (up_slot == lk_slot))
            view_tgt = up_target;
        else
            view_tgt = rd_tgts[lk_slot*PC_W +: PC_W];
        pred_c.hit    = lk_req && view_meta.valid && (view_meta.tag == lk_tag)
                        && view_meta.svld[lk_slot];
        pred_c.target = pred_c.hit ? view_tgt : '0;
    end

    assign lk_rnum = view_meta.rnum;

    always_ff @(posedge clk) begin
        if (rst) begin
            pv_q   <= 1'b0;
            pred_q <= '0;
        end else begin
            pv_q   <= lk_req;
            pred_q <= pred_c;
        end
    end

    assign pred_valid  = pv_q;
    assign pred_hit    = pred_q.hit;
    assign pred_target = pred_q.target;

    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> pred_valid); // R2
    AST_HIT_ONLY_WHEN_VALID: assert property (@(posedge clk) disable iff (rst)
        pred_hit |-> pred_valid); // R2
    AST_MISS_ZERO_TARGET: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (pred_target == '0)); // R3
    AST_UPDATE_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
        (up_en && lk_req && up_pc == lk_pc && up_slot == lk_slot)
        |=> (pred_hit && pred_target == $past(up_target))); // R9
endmodule

// File: tb/rhbtb_top_test.sv
`timescale 1ns/1ps
module rhbtb_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_req;
    logic [31:0] lk_pc;
    logic [4:0]  lk_rnum;
    logic [31:0] rf_data;
    logic        pred_valid, pred_hit;
    logic [31:0] pred_target;
    logic        up_en;
    logic [31:0] up_pc, up_rval, up_target;
    logic [4:0]  up_rnum;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rhbtb_top uut (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_pc(lk_pc), .lk_rnum(lk_rnum),
        .rf_data(rf_data), .pred_valid(pred_valid), .pred_hit(pred_hit),
        .pred_target(pred_target), .up_en(up_en), .up_pc(up_pc), .up_rnum(up_rnum),
        .up_rval(up_rval), .up_target(up_target)
    );

    typedef struct packed {
        logic        is_upd;
        logic [31:0] pc;
        logic [4:0]  rnum;
        logic [31:0] rval;
        logic [31:0] tgt;
        logic        exp_hit;
        logic [7:0]  req;
    } vec_t;

    localparam logic [31:0] PA = 32'h0000_1004;
    localparam logic [31:0] PB = 32'h0000_2004;

    // rval fold: 0->0, 1->1, 2->2, 3->3, 5->0
    localparam vec_t TBL [18] = '{
        '{1'b1, PA, 5'd3, 32'd0, 32'h100, 1'b0, 8'd7},
        '{1'b0, PA, 5'd3, 32'd0, 32'h100, 1'b1, 8'd3},
        '{1'b0, PA, 5'd3, 32'd1, 32'h0,   1'b0, 8'd10},
        '{1'b1, PA, 5'd3, 32'd1, 32'h200, 1'b0, 8'd8},
        '{1'b0, PA, 5'd3, 32'd1, 32'h200, 1'b1, 8'd10},
        '{1'b0, PA, 5'd3, 32'd0, 32'h100, 1'b1, 8'd8},
        '{1'b0, PA, 5'd3, 32'd5, 32'h100, 1'b1, 8'd4},
        '{1'b1, PA, 5'd7, 32'd2, 32'h300, 1'b0, 8'd8},
        '{1'b0, PA, 5'd7, 32'd2, 32'h300, 1'b1, 8'd8},
        '{1'b0, PB, 5'd7, 32'd0, 32'h0,   1'b0, 8'd6},
        '{1'b1, PB, 5'd4, 32'd0, 32'h400, 1'b0, 8'd7},
        '{1'b0, PB, 5'd4, 32'd0, 32'h400, 1'b1, 8'd5},
        '{1'b0, PB, 5'd4, 32'd1, 32'h0,   1'b0, 8'd7},
        '{1'b0, PA, 5'd4, 32'd0, 32'h0,   1'b0, 8'd6},
        '{1'b0, PB, 5'd4, 32'd3, 32'h0,   1'b0, 8'd7},
        '{1'b1, PB, 5'd4, 32'd3, 32'h500, 1'b0, 8'd8},
        '{1'b0, PB, 5'd4, 32'd3, 32'h500, 1'b1, 8'd4},
        '{1'b0, PB, 5'd4, 32'd0, 32'h400, 1'b1, 8'd8}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_update(input logic [31:0] pc, input logic [4:0] rn,
                             input logic [31:0] rv, input logic [31:0] tg);
        @(negedge clk);
        up_en = 1'b1; up_pc = pc; up_rnum = rn; up_rval = rv; up_target = tg;
        @(negedge clk);
        up_en = 1'b0;
    endtask

    task automatic do_lookup(input string req, input logic [31:0] pc,
                             input logic [31:0] rv, input logic [4:0] exp_rn,
                             input logic chk_rn, input logic exp_hit,
                             input logic [31:0] exp_tgt);
        @(negedge clk);
        lk_req = 1'b1; lk_pc = pc; rf_data = rv;
        #0.5;
        if (chk_rn) check("R5", "lk_rnum", 32'(lk_rnum), 32'(exp_rn));
        @(negedge clk);
        lk_req = 1'b0;
        check("R2", "pred_valid", 32'(pred_valid), 32'd1);
        check(req, "pred_hit", 32'(pred_hit), 32'(exp_hit));
        check(req, "pred_target", pred_target, exp_hit ? exp_tgt : 32'd0);
    endtask

    initial begin
        rst = 1'b1; lk_req = 1'b0; lk_pc = '0; rf_data = '0;
        up_en = 1'b0; up_pc = '0; up_rnum = '0; up_rval = '0; up_target = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, outputs idle and lookups miss
        check("R1", "pred_valid after reset", 32'(pred_valid), 32'd0);
        do_lookup("R1", PA, 32'd0, 5'd0, 1'b0, 1'b0, 32'd0);
        @(negedge clk);
        check("R2", "pred_valid idle", 32'(pred_valid), 32'd0);

        // Vector table: R3 R4 R6 R7 R8 R10
        for (int i = 0; i < 18; i++) begin
            string r;
            r = $sformatf("R%0d", TBL[i].req);
            if (TBL[i].is_upd)
                do_update(TBL[i].pc, TBL[i].rnum, TBL[i].rval, TBL[i].tgt);
            else
                do_lookup(r, TBL[i].pc, TBL[i].rval, TBL[i].rnum, 1'b1,
                          TBL[i].exp_hit, TBL[i].tgt);
        end

        // R9: update and lookup to one entry in the same cycle
        @(negedge clk);
        up_en = 1'b1; up_pc = 32'h0000_3008; up_rnum = 5'd2; up_rval = 32'd6; up_target = 32'h600;
        lk_req = 1'b1; lk_pc = 32'h0000_3008; rf_data = 32'd6;
        #0.5;
        check("R9", "lk_rnum bypass", 32'(lk_rnum), 32'd2);
        @(negedge clk);
        up_en = 1'b0; lk_req = 1'b0;
        check("R9", "pred_hit bypass", 32'(pred_hit), 32'd1);
        check("R9", "pred_target bypass", pred_target, 32'h600);

        // R1: reset again wipes entries written above
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_lookup("R1", PB, 32'd0, 5'd0, 1'b0, 1'b0, 32'd0);
        do_lookup("R1", 32'h0000_3008, 32'd6, 5'd0, 1'b0, 1'b0, 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule